// File: doc/BRIEF.md
# Serial LED Driver Configuration Interface

This block is the serial control front end of a sixteen-channel constant-current LED driver. A controller writes it over a single data pin. A mode input selects which of two shift chains that data enters. One chain holds a 16-bit on/off word, one bit per channel. The other chain is 112 bits long and carries a 7-bit dot-correction (brightness trim) value for every channel. A strobe input copies the selected chain into its holding latches. The latches then drive a channel-enable vector and sixteen trim words toward the analog sinks, which are outside this block.

The serial output always shows the last stage of the selected chain, so several devices can be chained. In enable mode, holding the strobe high after its rising edge makes the enable chain capture a 16-bit LED-open fault vector. The controller then clocks that vector out. A blank input turns every channel off without disturbing what is latched.

All pins are sampled on the system clock `clk` and are assumed to be synchronous to it already. Shift and strobe actions occur on the rising edges of `sclk` and `xlat` as seen in that clock domain.

Top module: `led_cfg_serial`

## Requirements
- R1: After reset, `chan_on` is all zeros, every dot-correction word in `dc_flat` is 0, and `sout` is 0.
- R2: With `mode`=0, each `sclk` rising edge shifts `sin` into bit 0 of the enable chain and moves the other bits up by one. After 16 shifts, the first bit sent sits in bit 15, which is channel 15. A following `xlat` rising edge makes `chan_on` equal to that 16-bit word.
- R3: With `mode`=1, 112 `sclk` rising edges fill the dot-correction chain. Channel 15's value goes first and each value is sent MSB first. After an `xlat` rising edge, `dc_flat[7n+6:7n]` holds channel n's value.
- R4: `sclk` edges shift only the chain that `mode` selects. The other chain keeps its contents.
- R5: An `xlat` rising edge updates only the latches of the selected chain. Outside such an edge, neither `chan_on` nor `dc_flat` changes, apart from the effect of `blank` on `chan_on`.
- R6: While `blank`=1, `chan_on` is all zeros. When `blank` returns to 0, the latched enable word reappears unchanged.
- R7: `sout` is bit 15 of the enable chain when `mode`=0 and bit 111 of the dot-correction chain when `mode`=1. Further shifts therefore bring the stored bits out in the order they were sent.
- R8: With `mode`=0, on every cycle after the `xlat` rising edge while `xlat` stays high, the enable chain loads `led_open` (bit n into stage n). This load overrides any `sclk` edge, and the edge that started it latches the data shifted in before the load.
- R9: While `xlat` is high with `mode`=1, `led_open` is not loaded into either chain.
- R10: A held-high `sclk` gives exactly one shift. Only a 0-to-1 change shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples all other inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial shift clock; a rising edge shifts the selected chain |
| xlat | input | 1 | Latch strobe; a rising edge copies the selected chain to its latches |
| mode | input | 1 | Chain select: 0 enable chain, 1 dot-correction chain |
| sin | input | 1 | Serial data in |
| blank | input | 1 | Forces all channel enables low while 1 |
| led_open | input | 16 | LED-open status, bit n for channel n |
| sout | output | 1 | Last stage of the selected chain |
| chan_on | output | 16 | Channel enables, bit n for channel n |
| dc_flat | output | 112 | Dot-correction words, channel n at bits 7n+6 to 7n |

## Verification
The bench keeps an enable word in the enable chain while the dot-correction chain is written, and then latches that word. A design that let one chain's shifts or strobe leak into the other would show a corrupted `chan_on` or `dc_flat`. It raises `sclk` during a held strobe, so a design that let shifting beat the status load, or that loaded status in dot-correction mode, reads back the wrong fault word or a stray all-ones enable vector. It also holds `sclk` high for several cycles, which a level-sensitive design would turn into a run of shifts. It reads the chain back through `sout`, so that reversed bit order or a wrong output tap shows as a mismatched word.

// File: rtl/led_cfg_serial.sv
module led_cfg_serial #(
  parameter int CHANNELS = 16,
  parameter int DC_BITS  = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sclk,
  input  logic                           xlat,
  input  logic                           mode,
  input  logic                           sin,
  input  logic                           blank,
  input  logic [CHANNELS-1:0]            led_open,
  output logic                           sout,
  output logic [CHANNELS-1:0]            chan_on,
  output logic [CHANNELS*DC_BITS-1:0]    dc_flat
);
  localparam int DC_LEN = CHANNELS * DC_BITS;

  logic [CHANNELS-1:0] en_sr, en_lat;
  logic [DC_LEN-1:0]   dc_sr, dc_lat;
  logic                sclk_q, xlat_q;
  logic                sclk_rise, xlat_rise;

  assign sclk_rise = sclk & ~sclk_q;
  assign xlat_rise = xlat & ~xlat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      xlat_q <= 1'b0;
      en_sr  <= '0;
      en_lat <= '0;
      dc_sr  <= '0;
      dc_lat <= '0;
    end else begin
      sclk_q <= sclk;
      xlat_q <= xlat;
      if (xlat_rise) begin
        if (mode) dc_lat <= dc_sr;
        else      en_lat <= en_sr;
      end else if (xlat && !mode) begin
        en_sr <= led_open;
      end else if (sclk_rise) begin
        if (mode) dc_sr <= {dc_sr[DC_LEN-2:0], sin};
        else      en_sr <= {en_sr[CHANNELS-2:0], sin};
      end
    end
  end

  assign sout    = mode ? dc_sr[DC_LEN-1] : en_sr[CHANNELS-1];
  assign chan_on = blank ? '0 : en_lat;
  assign dc_flat = dc_lat;
endmodule

// File: rtl/led_cfg_serial_chk.sv
module led_cfg_serial_chk #(
  parameter int CHANNELS = 16,
  parameter int DC_BITS  = 7
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        sclk,
  input logic                        xlat,
  input logic                        mode,
  input logic                        blank,
  input logic                        led_msb,
  input logic                        sout,
  input logic [CHANNELS-1:0]         chan_on,
  input logic [CHANNELS*DC_BITS-1:0] dc_flat
);
  assert_dc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(xlat) || !$past(mode)) |-> $stable(dc_flat));

  assert_en_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((!$past(xlat) || $past(mode)) && $stable(blank)) |-> $stable(chan_on));

  assert_blank_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && $past(blank)) |-> (chan_on == '0));

  assert_sout_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(mode) && !$past(xlat) && !($past(sclk) && !$past(sclk, 2))) |-> $stable(sout));

  assert_status_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xlat) && $past(xlat, 2) && !$past(mode) && !mode) |-> (sout == $past(led_msb)));
endmodule

bind led_cfg_serial led_cfg_serial_chk #(.CHANNELS(CHANNELS), .DC_BITS(DC_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .xlat(xlat), .mode(mode), .blank(blank),
  .led_msb(led_open[CHANNELS-1]), .sout(sout), .chan_on(chan_on), .dc_flat(dc_flat)
);

// File: tb/sim_led_cfg_serial.sv
module sim_led_cfg_serial;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, xlat = 1'b0, mode = 1'b0, sin = 1'b0, blank = 1'b0;
  logic [15:0]  led_open = '0;
  logic         sout;
  logic [15:0]  chan_on;
  logic [111:0] dc_flat;
  logic [111:0] exp_dc;
  int checks = 0, failures = 0;
  bit done = 0;

  led_cfg_serial u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .xlat(xlat), .mode(mode),
    .sin(sin), .blank(blank), .led_open(led_open), .sout(sout), .chan_on(chan_on), .dc_flat(dc_flat));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [111:0] act, input logic [111:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shift_read(input logic b, output logic o);
    @(negedge clk);
    o = sout;
    sin = b;
    sclk = 1'b1;
    @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic shift_word(input logic [15:0] w);
    logic o;
    for (int i = 15; i >= 0; i--) shift_read(w[i], o);
  endtask

  task automatic read_word(output logic [15:0] w);
    logic o;
    for (int i = 15; i >= 0; i--) begin
      shift_read(1'b0, o);
      w[i] = o;
    end
  endtask

  task automatic pulse_xlat(input int hold);
    @(negedge clk);
    xlat = 1'b1;
    repeat (hold) @(negedge clk);
    xlat = 1'b0;
  endtask

  function automatic logic [6:0] dc_val(input int n);
    return 7'((n * 9 + 70) & 127);
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk("R1 chan_on", 112'(chan_on), 112'h0);
    chk("R1 dc_flat", dc_flat, 112'h0);
    chk("R1 sout", 112'(sout), 112'h0);
  endtask

  task automatic t_enable;
    mode = 1'b0;
    shift_word(16'hA5C3);
    pulse_xlat(1);
    chk("R2 chan_on", 112'(chan_on), 112'hA5C3);
  endtask

  task automatic t_cascade;
    logic [15:0] w;
    read_word(w);
    chk("R7 sout order", 112'(w), 112'hA5C3);
    shift_word(16'h3C5A);
  endtask

  task automatic t_dc;
    logic o;
    mode = 1'b1;
    for (int n = 15; n >= 0; n--) begin
      exp_dc[n*7 +: 7] = dc_val(n);
      for (int b = 6; b >= 0; b--) shift_read(dc_val(n)/*value*/ [b], o);
    end
    @(negedge clk);
    chk("R7 sout dc tap", 112'(sout), 112'h1);
    pulse_xlat(1);
    chk("R3 dc_flat", dc_flat, exp_dc);
    chk("R5 chan_on kept on dc latch", 112'(chan_on), 112'hA5C3);
    mode = 1'b0;
    @(negedge clk);
    chk("R7 sout en tap", 112'(sout), 112'h0);
    pulse_xlat(1);
    chk("R4 en chain kept", 112'(chan_on), 112'h3C5A);
    chk("R5 dc kept on en latch", dc_flat, exp_dc);
  endtask

  task automatic t_blank;
    blank = 1'b1;
    @(negedge clk);
    chk("R6 blank off", 112'(chan_on), 112'h0);
    repeat (3) @(negedge clk);
    blank = 1'b0;
    @(negedge clk);
    chk("R6 restore", 112'(chan_on), 112'h3C5A);
  endtask

  task automatic t_status;
    logic [15:0] w;
    led_open = 16'h9E21;
    mode = 1'b0;
    @(negedge clk);
    xlat = 1'b1;
    @(negedge clk);
    sin = 1'b1;
    sclk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    xlat = 1'b0;
    sclk = 1'b0;
    sin = 1'b0;
    chk("R8 latched pre-status", 112'(chan_on), 112'h3C5A);
    read_word(w);
    chk("R8 status readback", 112'(w), 112'h9E21);
  endtask

  task automatic t_dc_xlat;
    led_open = 16'hFFFF;
    mode = 1'b1;
    pulse_xlat(3);
    chk("R9 dc relatched", dc_flat, exp_dc);
    mode = 1'b0;
    pulse_xlat(1);
    chk("R9 no status in dc mode", 112'(chan_on), 112'h0);
  endtask

  task automatic t_edge;
    mode = 1'b0;
    @(negedge clk);
    sin = 1'b1;
    sclk = 1'b1;
    repeat (5) @(negedge clk);
    sclk = 1'b0;
    sin = 1'b0;
    pulse_xlat(1);
    chk("R10 single shift", 112'(chan_on), 112'h0001);
  endtask

  initial begin
    exp_dc = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_enable;
    t_cascade;
    t_dc;
    t_blank;
    t_status;
    t_dc_xlat;
    t_edge;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule